// File: doc/BRIEF.md
# Serial Flash Write-Protection Unit

This block decides whether a program or erase request may touch the array of a 128 Mbit serial NOR flash model. It sits behind the serial front end and receives commands that are already decoded: an opcode, a 24-bit address and, for a register write, a 16-bit data word. It holds a write-enable latch, a four-bit region-protect code, a sticky top/bottom select and a one-time switch that moves the device from region protection to per-unit locks. The array controller presents each program or erase request on a separate request port and receives a single protected flag one cycle later.

Region protection covers a power-of-two number of 64 KB blocks counted from the top or the bottom of the array. Per-unit locking uses a mixed map: each of the sixteen 4 KB sectors in the lowest and highest 64 KB block has its own lock bit, and every 64 KB block in between has one lock bit. Lock bits are volatile and return to locked on every reset. The region code, the top/bottom select and the mode switch are non-volatile. Only a power-up clears them.

Top module: `flash_wprot`

## Requirements
- R1: After power-up (`porN` low), the status byte, configuration byte and security byte all read 0x00. The write-enable latch is clear, the region code is 0, bottom protection is off and region mode is active. No request is flagged, chip erase included.
- R2: In region mode, let code be status bits [5:2]. Code 0 protects nothing. Code n from 1 to 8 protects 2^(n-1) 64 KB blocks. Codes 9 to 15 protect the whole array. With configuration bit 3 clear, the count runs down from block 255. A chip erase is flagged whenever the count is non-zero.
- R3: Register write 0x01 takes the status byte from `cmdData[7:0]` and the configuration byte from `cmdData[15:8]`. Configuration bit 3 (data bit 11) makes the protected blocks count up from block 0. Once set, it stays set until the next power-up.
- R4: Opcode 0x68 switches to per-unit lock mode, which the security byte shows as bit 7. Only a power-up leaves this mode. While per-unit mode is active, the region code has no effect on protection.
- R5: Unit map: address bits [23:16] select the block. In blocks 0 and 255, address bits [15:12] select one of 16 separate 4 KB units. Blocks 1 to 254 are one unit each, which gives 286 units in total.
- R6: Opcode 0x06 sets the write-enable latch (status bit 1) and opcode 0x04 clears it. Opcodes 0x01, 0x68, 0x36, 0x39, 0x7E and 0x98 always clear the latch. They take effect only if the latch was set when they arrived.
- R7: In per-unit mode, 0x36 locks and 0x39 unlocks the single unit that holds `cmdAddr`. No other unit changes.
- R8: In per-unit mode, 0x7E locks every unit and 0x98 unlocks every unit.
- R9: Every lock bit is set by power-up and by `rstN`. `rstN` also clears the write-enable latch. It leaves the region code, the top/bottom select and the mode switch unchanged.
- R10: The request kind is 0 for program, 1 for 4 KB erase, 2 for 64 KB erase and 3 for chip erase. A 64 KB erase in block 0 or block 255 is flagged if any of its 16 units is locked. A chip erase is flagged if any unit is locked.
- R11: Opcode 0x3C raises `rdValid` for one cycle, on the cycle after the command. `rdLocked` then carries the protection state of the unit that holds `cmdAddr`. In region mode this is the region result.
- R12: `protValid` follows `reqValid` by exactly one cycle. `protFlag` is evaluated against the state in the cycle of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-up reset, active low, synchronous; clears all state |
| rstN | input | 1 | Device reset, active low, synchronous; relocks units and clears the latch |
| cmdValid | input | 1 | A decoded command is present this cycle |
| cmdOp | input | 8 | Command opcode |
| cmdAddr | input | 24 | Command address |
| cmdData | input | 16 | Register write data: [7:0] status, [15:8] configuration |
| reqValid | input | 1 | A program or erase request is present |
| reqKind | input | 2 | 0 program, 1 erase 4 KB, 2 erase 64 KB, 3 chip erase |
| reqAddr | input | 24 | Request address |
| protValid | output | 1 | Protection result is valid |
| protFlag | output | 1 | Request targets protected memory |
| rdValid | output | 1 | Lock-status read result is valid |
| rdLocked | output | 1 | Unit addressed by the read is protected |
| statusOut | output | 8 | Status byte: bit1 write-enable latch, bits[5:2] region code |
| cfgOut | output | 8 | Configuration byte: bit3 bottom select |
| secOut | output | 8 | Security byte: bit7 per-unit mode |

## Verification
The bench builds the block with its default 24-bit address, which gives 256 blocks and the full 286-unit lock map. At this size a sweep of all 16 region codes against every block, with both top/bottom settings, stays cheap. The lock checks also reach the real unit boundaries: the first and last 4 KB units of the two end blocks, and the first and last 64 KB middle blocks. The expected results come from the count formula and the unit map, both worked out inside the bench.

// File: rtl/flash_wprot_pkg.sv
package flash_wprot_pkg;

  // Decoded opcodes handled by the protection unit
  localparam logic [7:0] OP_WEL_SET  = 8'h06;
  localparam logic [7:0] OP_WEL_CLR  = 8'h04;
  localparam logic [7:0] OP_REG_WR   = 8'h01;
  localparam logic [7:0] OP_MODE_SEL = 8'h68;
  localparam logic [7:0] OP_LOCK1    = 8'h36;
  localparam logic [7:0] OP_UNLOCK1  = 8'h39;
  localparam logic [7:0] OP_LOCKALL  = 8'h7E;
  localparam logic [7:0] OP_UNLKALL  = 8'h98;
  localparam logic [7:0] OP_LOCKRD   = 8'h3C;

  // Address split: 64 KB blocks, 4 KB sectors
  localparam int BLK_SHIFT = 16;
  localparam int SEC_SHIFT = 12;
  localparam int SEC_PER_BLK_W = BLK_SHIFT - SEC_SHIFT;

  typedef enum logic [1:0] {
    REQ_PROG  = 2'd0,
    REQ_ER4K  = 2'd1,
    REQ_ER64K = 2'd2,
    REQ_CHIP  = 2'd3
  } reqKind_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic welSet;
    logic welClr;
    logic regWrite;
    logic modeSet;
    logic lockOne;
    logic unlockOne;
    logic lockAll;
    logic unlockAll;
    logic lockRead;
  } wpStrobe_t;

endpackage

// File: rtl/flash_wprot_ctrl.sv
module flash_wprot_ctrl
  import flash_wprot_pkg::*;
(
  input  logic       cmdValid,
  input  logic [7:0] cmdOp,
  input  logic       welQ,
  input  logic       modeQ,
  output wpStrobe_t  stb
);

  logic guarded;

  always_comb begin
    stb = '0;
    guarded = 1'b0;
    if (cmdValid) begin
      unique case (cmdOp)
        OP_WEL_SET:  stb.welSet = 1'b1;
        OP_WEL_CLR:  stb.welClr = 1'b1;
        OP_REG_WR:   begin guarded = 1'b1; stb.regWrite  = welQ; end
        OP_MODE_SEL: begin guarded = 1'b1; stb.modeSet   = welQ; end
        OP_LOCK1:    begin guarded = 1'b1; stb.lockOne   = welQ & modeQ; end
        OP_UNLOCK1:  begin guarded = 1'b1; stb.unlockOne = welQ & modeQ; end
        OP_LOCKALL:  begin guarded = 1'b1; stb.lockAll   = welQ & modeQ; end
        OP_UNLKALL:  begin guarded = 1'b1; stb.unlockAll = welQ & modeQ; end
        OP_LOCKRD:   stb.lockRead = 1'b1;
        default:     ;
      endcase
      // every guarded command drops the latch afterwards (R6)
      if (guarded) stb.welClr = 1'b1;
    end
  end

endmodule

// File: rtl/flash_wprot_dp.sv
module flash_wprot_dp
  import flash_wprot_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  wpStrobe_t         stb,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [15:0]       cmdData,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              welQ,
  output logic              modeQ,
  output logic              protValid,
  output logic              protFlag,
  output logic              rdValid,
  output logic              rdLocked,
  output logic [7:0]        statusOut,
  output logic [7:0]        cfgOut,
  output logic [7:0]        secOut
);

  localparam int BLK_IDX_W = ADDR_W - BLK_SHIFT;
  localparam int SA_W      = ADDR_W - SEC_SHIFT;
  localparam int NBLK      = 1 << BLK_IDX_W;
  localparam int SUBS      = 1 << SEC_PER_BLK_W;
  localparam int NUNIT     = 2 * SUBS + NBLK - 2;
  localparam int UIDX_W    = $clog2(NUNIT);

  logic [3:0]       bpQ;
  logic             tbQ;
  logic [NUNIT-1:0] lockQ;
  logic [SA_W-1:0]  cmdSa, reqSa;
  logic             reqProt, cmdProt;
  logic [UIDX_W-1:0] cmdUnit;
  logic             unusedBits;

  assign cmdSa = cmdAddr[ADDR_W-1:SEC_SHIFT];
  assign reqSa = reqAddr[ADDR_W-1:SEC_SHIFT];
  assign unusedBits = ^{cmdAddr[SEC_SHIFT-1:0], reqAddr[SEC_SHIFT-1:0],
                        cmdData[15:12], cmdData[10:6], cmdData[1:0]};

  // Number of 64 KB blocks covered by a region code (R2)
  function automatic logic [BLK_IDX_W:0] bpCount(input logic [3:0] bp);
    if (bp == 4'd0) return '0;
    else if (int'(bp) - 1 >= BLK_IDX_W) return (BLK_IDX_W+1)'(NBLK);
    else return (BLK_IDX_W+1)'(1) << (bp - 4'd1);
  endfunction

  function automatic logic blockInRegion(input logic [BLK_IDX_W-1:0] blk,
                                         input logic [3:0] bp, input logic tb);
    logic [BLK_IDX_W:0] cnt, ext;
    cnt = bpCount(bp);
    ext = {1'b0, blk};
    if (tb) return ext < cnt;
    return ext >= ((BLK_IDX_W+1)'(NBLK) - cnt);
  endfunction

  // Mixed-granularity unit index (R5)
  function automatic logic [UIDX_W-1:0] unitOf(input logic [SA_W-1:0] sa);
    logic [BLK_IDX_W-1:0]     blk;
    logic [SEC_PER_BLK_W-1:0] sec;
    blk = sa[SA_W-1:SEC_PER_BLK_W];
    sec = sa[SEC_PER_BLK_W-1:0];
    if (blk == '0)      return UIDX_W'(sec);
    else if (blk == '1) return UIDX_W'(SUBS + NBLK - 2) + UIDX_W'(sec);
    else                return UIDX_W'(SUBS - 1) + UIDX_W'(blk);
  endfunction

  function automatic logic evalProt(input reqKind_e k, input logic [SA_W-1:0] sa,
                                    input logic [NUNIT-1:0] lk, input logic [3:0] bp,
                                    input logic tb, input logic mode);
    logic [BLK_IDX_W-1:0] blk;
    blk = sa[SA_W-1:SEC_PER_BLK_W];
    if (!mode) begin
      if (k == REQ_CHIP) return bpCount(bp) != '0;
      return blockInRegion(blk, bp, tb);
    end
    if (k == REQ_CHIP) return |lk;
    if (k == REQ_ER64K && blk == '0) return |lk[SUBS-1:0];
    if (k == REQ_ER64K && blk == '1) return |lk[NUNIT-1 -: SUBS];
    return lk[unitOf(sa)];
  endfunction

  always_comb begin
    reqProt = evalProt(reqKind_e'(reqKind), reqSa, lockQ, bpQ, tbQ, modeQ);
    cmdProt = evalProt(REQ_PROG, cmdSa, lockQ, bpQ, tbQ, modeQ);
    cmdUnit = unitOf(cmdSa);
  end

  // Non-volatile state: cleared only by power-up
  always_ff @(posedge clk) begin
    if (!porN) begin
      bpQ   <= '0;
      tbQ   <= 1'b0;
      modeQ <= 1'b0;
    end else begin
      if (stb.regWrite) begin
        bpQ <= cmdData[5:2];
        tbQ <= tbQ | cmdData[11];
      end
      if (stb.modeSet) modeQ <= 1'b1;
    end
  end

  // Volatile state
  always_ff @(posedge clk) begin
    if (!porN || !rstN) begin
      welQ      <= 1'b0;
      lockQ     <= '1;
      protValid <= 1'b0;
      protFlag  <= 1'b0;
      rdValid   <= 1'b0;
      rdLocked  <= 1'b0;
    end else begin
      if (stb.welClr)      welQ <= 1'b0;
      else if (stb.welSet) welQ <= 1'b1;

      if (stb.lockAll)        lockQ <= '1;
      else if (stb.unlockAll) lockQ <= '0;
      else if (stb.lockOne)   lockQ[cmdUnit] <= 1'b1;
      else if (stb.unlockOne) lockQ[cmdUnit] <= 1'b0;

      protValid <= reqValid;
      protFlag  <= reqProt;
      rdValid   <= stb.lockRead;
      rdLocked  <= cmdProt;
    end
  end

  assign statusOut = {2'b00, bpQ, welQ, 1'b0};
  assign cfgOut    = {4'b0000, tbQ, 3'b000};
  assign secOut    = {modeQ, 7'b0000000};

  // R3: bottom select never returns to top
  a_r3_tb_sticky: assert property (@(posedge clk) disable iff (!porN)
    tbQ |=> tbQ);

  // R4: per-unit mode is irreversible
  a_r4_mode_sticky: assert property (@(posedge clk) disable iff (!porN)
    modeQ |=> modeQ);

  // R6: a lock bit only moves after a latched-enable command in per-unit mode
  a_r6_lock_needs_wel: assert property (@(posedge clk) disable iff (!porN || !rstN)
    ($past(porN) && $past(rstN) && (lockQ != $past(lockQ))) |-> $past(welQ && modeQ));

  // R9: device reset relocks every unit
  a_r9_reset_locks: assert property (@(posedge clk) disable iff (!porN)
    !rstN |=> (&lockQ));

  // R2: code 0 protects nothing, code 15 protects everything
  a_r2_code_zero: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (reqValid && !modeQ && bpQ == 4'd0) |=> (protValid && !protFlag));
  a_r2_code_full: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (reqValid && !modeQ && bpQ == 4'hF) |=> (protValid && protFlag));

  // R8: with every unit unlocked no request is flagged
  a_r8_all_open: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (reqValid && modeQ && lockQ == '0) |=> !protFlag);

endmodule

// File: rtl/flash_wprot.sv
module flash_wprot
  import flash_wprot_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [15:0]       cmdData,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              protValid,
  output logic              protFlag,
  output logic              rdValid,
  output logic              rdLocked,
  output logic [7:0]        statusOut,
  output logic [7:0]        cfgOut,
  output logic [7:0]        secOut
);

  wpStrobe_t stb;
  logic      welQ;
  logic      modeQ;

  flash_wprot_ctrl u_ctrl (
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .welQ     (welQ),
    .modeQ    (modeQ),
    .stb      (stb)
  );

  flash_wprot_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .porN      (porN),
    .rstN      (rstN),
    .stb       (stb),
    .cmdAddr   (cmdAddr),
    .cmdData   (cmdData),
    .reqValid  (reqValid),
    .reqKind   (reqKind),
    .reqAddr   (reqAddr),
    .welQ      (welQ),
    .modeQ     (modeQ),
    .protValid (protValid),
    .protFlag  (protFlag),
    .rdValid   (rdValid),
    .rdLocked  (rdLocked),
    .statusOut (statusOut),
    .cfgOut    (cfgOut),
    .secOut    (secOut)
  );

endmodule

// File: tb/flash_wprot_tb.sv
`timescale 1ns/1ps
module flash_wprot_tb;

  logic        clk = 1'b0;
  logic        porN = 1'b0, rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [7:0]  cmdOp = '0;
  logic [23:0] cmdAddr = '0;
  logic [15:0] cmdData = '0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = '0;
  logic [23:0] reqAddr = '0;
  logic        protValid, protFlag, rdValid, rdLocked;
  logic [7:0]  statusOut, cfgOut, secOut;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  flash_wprot u_dut (
    .clk(clk), .porN(porN), .rstN(rstN),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .reqValid(reqValid), .reqKind(reqKind), .reqAddr(reqAddr),
    .protValid(protValid), .protFlag(protFlag),
    .rdValid(rdValid), .rdLocked(rdLocked),
    .statusOut(statusOut), .cfgOut(cfgOut), .secOut(secOut)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] op, input logic [23:0] a, input logic [15:0] d);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic wrRegs(input logic [15:0] d);
    cmd(8'h06, 24'h0, 16'h0);
    cmd(8'h01, 24'h0, d);
  endtask

  task automatic query(input string req, input int kind, input logic [23:0] a, input int exp);
    @(negedge clk);
    reqValid = 1'b1; reqKind = 2'(kind); reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    check({req, " valid"}, int'(protValid), 1);
    check(req, int'(protFlag), exp);
  endtask

  task automatic rdLock(input string req, input logic [23:0] a, input int exp);
    cmd(8'h3C, a, 16'h0);
    check({req, " rdValid"}, int'(rdValid), 1);
    check(req, int'(rdLocked), exp);
  endtask

  task automatic lockAt(input logic [23:0] a);   cmd(8'h06, 0, 0); cmd(8'h36, a, 0); endtask
  task automatic unlockAt(input logic [23:0] a); cmd(8'h06, 0, 0); cmd(8'h39, a, 0); endtask

  // Region model (R2/R3): blocks covered by a code, counted from one end
  function automatic int expRegion(input int blk, input int bp, input int tb);
    int cnt;
    cnt = (bp == 0) ? 0 : (bp > 8) ? 256 : (1 << (bp - 1));
    if (tb != 0) return (blk < cnt) ? 1 : 0;
    return (blk >= 256 - cnt) ? 1 : 0;
  endfunction

  task automatic sweep(input int tb);
    for (int bp = 0; bp < 16; bp++) begin
      wrRegs({(tb != 0) ? 8'h08 : 8'h00, 2'b00, 4'(bp), 2'b00});
      check("R6 latch cleared after write", int'(statusOut), bp << 2);
      for (int blk = 0; blk < 256; blk++)
        query(tb != 0 ? "R3 bottom region" : "R2 top region", blk % 3,
              24'((blk << 16) | 16'h5A5A), expRegion(blk, bp, tb));
      query("R2 chip erase region", 3, 24'h0, (bp != 0) ? 1 : 0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    porN = 1'b1; rstN = 1'b1;
    @(negedge clk);
    // R1 power-up defaults
    check("R1 status", int'(statusOut), 0);
    check("R1 config", int'(cfgOut), 0);
    check("R1 security", int'(secOut), 0);
    query("R1 chip erase open", 3, 24'h0, 0);

    // R6 latch gating
    cmd(8'h01, 0, 16'h003C);
    check("R6 write without latch ignored", int'(statusOut), 0);
    cmd(8'h06, 0, 0);
    check("R6 latch set", int'(statusOut), 8'h02);
    cmd(8'h04, 0, 0);
    check("R6 latch clear", int'(statusOut), 0);

    // R2 / R3 sweeps
    sweep(0);
    wrRegs(16'h0800);
    check("R3 bottom select set", int'(cfgOut), 8'h08);
    wrRegs(16'h0000);
    check("R3 bottom select sticky", int'(cfgOut), 8'h08);
    sweep(1);

    // R11 read in region mode (bottom, code 1 -> block 0)
    wrRegs(16'h0804);
    rdLock("R11 region read protected", 24'h00_8000, 1);
    rdLock("R11 region read open", 24'h01_0000, 0);

    // R4 mode switch
    wrRegs(16'h0800);
    cmd(8'h68, 0, 0);
    check("R6 mode select without latch ignored", int'(secOut), 0);
    cmd(8'h06, 0, 0);
    cmd(8'h68, 0, 0);
    check("R4 per-unit mode", int'(secOut), 8'h80);
    check("R6 latch cleared by mode select", int'(statusOut[1]), 0);
    query("R9 default locked low", 0, 24'h00_0000, 1);
    query("R9 default locked mid", 0, 24'h80_0000, 1);
    query("R9 default locked high", 0, 24'hFF_F000, 1);

    cmd(8'h06, 0, 0); cmd(8'h98, 0, 0);
    wrRegs(16'h083C);
    query("R4 region code ignored", 0, 24'h80_0000, 0);
    query("R8 chip open after global unlock", 3, 24'h0, 0);

    // R5 / R7 / R10 / R11 boundary units
    lockAt(24'h00_0000);
    query("R7 bottom unit0 locked", 0, 24'h00_0FFF, 1);
    query("R5 bottom unit1 open", 0, 24'h00_1000, 0);
    query("R10 64K erase block0 flagged", 2, 24'h00_F000, 1);
    query("R5 4K erase unit1 open", 1, 24'h00_1000, 0);
    query("R10 chip erase flagged", 3, 24'h0, 1);
    rdLock("R11 read locked", 24'h00_0800, 1);
    rdLock("R11 read open", 24'h00_1000, 0);
    unlockAt(24'h00_0ABC);
    query("R7 unlock unit0", 0, 24'h00_0000, 0);

    lockAt(24'h00_F000);
    query("R7 bottom unit15 locked", 0, 24'h00_FFFF, 1);
    query("R5 first middle block open", 0, 24'h01_0000, 0);
    query("R5 bottom unit14 open", 0, 24'h00_E000, 0);
    unlockAt(24'h00_F000);

    lockAt(24'h01_0000);
    query("R7 middle block1 locked", 0, 24'h01_FFFF, 1);
    query("R5 middle 4K erase uses block", 1, 24'h01_3000, 1);
    query("R5 middle block2 open", 0, 24'h02_0000, 0);
    query("R5 bottom unit15 open", 0, 24'h00_F000, 0);
    unlockAt(24'h01_0000);

    lockAt(24'hFE_FFFF);
    query("R7 middle block254 locked", 0, 24'hFE_0000, 1);
    query("R5 top unit0 open", 0, 24'hFF_0000, 0);
    unlockAt(24'hFE_0000);

    lockAt(24'hFF_0000);
    query("R7 top unit0 locked", 0, 24'hFF_0FFF, 1);
    query("R5 top unit1 open", 0, 24'hFF_1000, 0);
    query("R10 64K erase block255 flagged", 2, 24'hFF_8000, 1);
    query("R10 64K erase block254 open", 2, 24'hFE_0000, 0);
    unlockAt(24'hFF_0000);

    lockAt(24'hFF_F000);
    query("R7 top unit15 locked", 0, 24'hFF_FFFF, 1);
    query("R5 top unit14 open", 0, 24'hFF_EFFF, 0);
    unlockAt(24'hFF_F000);

    cmd(8'h36, 24'h30_0000, 0);
    query("R6 lock without latch ignored", 0, 24'h30_0000, 0);
    query("R10 chip open when all unlocked", 3, 24'h0, 0);

    // R8 global lock
    cmd(8'h06, 0, 0); cmd(8'h7E, 0, 0);
    query("R8 global lock low", 0, 24'h00_3000, 1);
    query("R8 global lock mid", 1, 24'h55_0000, 1);

    // R9 device reset
    cmd(8'h06, 0, 0); cmd(8'h98, 0, 0);
    cmd(8'h06, 0, 0);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check("R9 mode kept", int'(secOut), 8'h80);
    check("R9 bottom select kept", int'(cfgOut), 8'h08);
    check("R9 code kept, latch cleared", int'(statusOut), 8'h3C);
    query("R9 relocked after reset", 0, 24'h40_0000, 1);

    // R1 power-up again
    @(negedge clk); porN = 1'b0;
    @(negedge clk); porN = 1'b1;
    check("R1 security after power-up", int'(secOut), 0);
    check("R1 config after power-up", int'(cfgOut), 0);
    check("R1 status after power-up", int'(statusOut), 0);
    query("R12 chip open after power-up", 3, 24'h0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule